// File: doc/BRIEF.md
# Selectable-Precision Significand Rounder

This block takes an unrounded result made of a sign, a biased exponent, a 64-bit significand and three extra low-order bits (guard, round, sticky). It rounds the magnitude to one of three kept widths (24, 53 or 64 bits) in one of four rounding directions. It returns the rounded significand, which is still left-aligned in the 64-bit field. It also returns the exponent, adjusted when rounding carries out of the kept field, and a flag that reports whether any discarded information was non-zero.

The rounding direction and precision are held in a small mode register. Software-side logic loads this register with a one-cycle write strobe, and the setting applies to every later sample. A sample is presented with a valid strobe, and its result appears registered one clock later. Range checks on the exponent, denormal handling and special operands are handled elsewhere in the arithmetic pipeline.

Top module: `rnd_unit`

## Requirements
- R1: While reset is asserted and after it is released, out_valid, out_sig, out_exp and out_inexact are zero. Until the first mode write, the mode is nearest-even (direction code 00) at 64-bit precision (precision code 11).
- R2: A sample accepted with in_valid high gives its result on the outputs with out_valid high exactly one clock later. out_valid is low in every cycle that follows a cycle with in_valid low.
- R3: Precision codes are 00 for 24 kept bits, 10 for 53 and 11 for 64. Code 01 acts as 64. Output significand bits below the kept width are always zero.
- R4: Direction code 00 rounds to nearest. On an exact halfway case it rounds to the value whose kept least significant bit is 0.
- R5: Direction code 01 (toward minus infinity) adds one unit in the last kept place only when the sign is 1 and the result is inexact.
- R6: Direction code 10 (toward plus infinity) adds one unit in the last kept place only when the sign is 0 and the result is inexact.
- R7: Direction code 11 (toward zero) never adds to the magnitude. The kept bits pass through unchanged.
- R8: out_inexact is 1 exactly when any discarded significand bit, or guard, round or sticky, is 1.
- R9: When the increment carries out of the kept field, the output significand is 1 in bit 63 and zero in every other bit, and out_exp is in_exp plus one (modulo 2^16). Otherwise out_exp equals in_exp.
- R10: cfg_we loads cfg_rc and cfg_pc into the mode register at the clock edge. A sample accepted at that same edge is still rounded with the previous mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Mode register write strobe |
| cfg_rc | input | 2 | Rounding direction to load |
| cfg_pc | input | 2 | Precision code to load |
| in_valid | input | 1 | Sample strobe |
| in_sign | input | 1 | Sign of the value being rounded |
| in_exp | input | 16 | Exponent of the value |
| in_sig | input | 64 | Unrounded significand, left-aligned |
| in_guard | input | 1 | First bit below the significand |
| in_round | input | 1 | Second bit below the significand |
| in_sticky | input | 1 | OR of all further bits |
| out_valid | output | 1 | Result strobe |
| out_sig | output | 64 | Rounded significand |
| out_exp | output | 16 | Exponent after carry adjustment |
| out_inexact | output | 1 | Discarded information was non-zero |

## Verification
The bench targets exact halfway cases with both parities of the kept LSB. A rounder that ignores ties-to-even would drift upward on even values, and one that checks the wrong bit as round bit would misclassify them entirely. All-ones significands force the carry path at every precision. A design that mishandles it would wrap to zero or leave the exponent alone. Samples whose only non-zero bits lie just under the 24- or 53-bit boundary expose folding mistakes: a wrong boundary leaks low bits to the output or misses the inexact flag. A write coinciding with a sample shows whether the mode register is bypassed too early.

// File: rtl/rnd_pkg.sv
package rnd_pkg;

  typedef enum logic [1:0] {
    RC_NEAR = 2'b00,
    RC_DOWN = 2'b01,
    RC_UP   = 2'b10,
    RC_ZERO = 2'b11
  } rc_e;

  typedef enum logic [1:0] {
    PC_SHORT = 2'b00,
    PC_SPARE = 2'b01,
    PC_MID   = 2'b10,
    PC_FULL  = 2'b11
  } pc_e;

  // decision inputs after folding discarded bits
  typedef struct packed {
    logic lsb;
    logic rbit;
    logic stk;
  } rnd_bits_t;

  localparam int NUM_LANES = 3;

endpackage

// File: rtl/rnd_mode_reg.sv
module rnd_mode_reg
  import rnd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_we,
  input  logic [1:0] cfg_rc,
  input  logic [1:0] cfg_pc,
  output rc_e  rc_q,
  output pc_e  pc_q
);

  rc_e rc_d;
  pc_e pc_d;

  always_comb begin
    rc_d = rc_q;
    pc_d = pc_q;
    if (cfg_we) begin
      rc_d = rc_e'(cfg_rc);
      pc_d = pc_e'(cfg_pc);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rc_q <= RC_NEAR;
      pc_q <= PC_FULL;
    end else begin
      rc_q <= rc_d;
      pc_q <= pc_d;
    end
  end

  // R10: without a write strobe the mode does not move
  a_r10_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable({rc_q, pc_q}));

endmodule

// File: rtl/rnd_fold.sv
module rnd_fold
  import rnd_pkg::*;
#(
  parameter int SIG_W = 64,
  parameter int P_LO  = 24,
  parameter int P_MID = 53
)(
  input  logic [SIG_W-1:0] sig,
  input  logic [2:0]       grs,
  input  pc_e              pc,
  output logic [SIG_W-1:0] kept,
  output logic [SIG_W-1:0] unit,
  output rnd_bits_t        bits
);

  localparam int WIDTHS [NUM_LANES] = '{P_LO, P_MID, SIG_W};

  logic [SIG_W-1:0] lane_kept [NUM_LANES];
  logic [SIG_W-1:0] lane_unit [NUM_LANES];
  rnd_bits_t        lane_bits [NUM_LANES];

  for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
    localparam int DROP = SIG_W - WIDTHS[k];
    localparam logic [SIG_W-1:0] KMASK = {SIG_W{1'b1}} << DROP;
    assign lane_kept[k] = sig & KMASK;
    assign lane_unit[k] = {{(SIG_W-1){1'b0}}, 1'b1} << DROP;
    if (DROP == 0) begin : g_full
      assign lane_bits[k].lsb  = sig[0];
      assign lane_bits[k].rbit = grs[2];
      assign lane_bits[k].stk  = grs[1] | grs[0];
    end else if (DROP == 1) begin : g_one
      assign lane_bits[k].lsb  = sig[1];
      assign lane_bits[k].rbit = sig[0];
      assign lane_bits[k].stk  = |grs;
    end else begin : g_many
      assign lane_bits[k].lsb  = sig[DROP];
      assign lane_bits[k].rbit = sig[DROP-1];
      assign lane_bits[k].stk  = (|sig[DROP-2:0]) | (|grs);
    end
  end

  logic [1:0] sel;

  always_comb begin
    unique case (pc)
      PC_SHORT: sel = 2'd0;
      PC_MID:   sel = 2'd1;
      default:  sel = 2'd2;
    endcase
    kept = lane_kept[sel];
    unit = lane_unit[sel];
    bits = lane_bits[sel];
  end

endmodule

// File: rtl/rnd_decide.sv
module rnd_decide
  import rnd_pkg::*;
(
  input  logic      sign,
  input  rc_e       rc,
  input  rnd_bits_t bits,
  output logic      inc,
  output logic      inexact
);

  logic lost;

  always_comb begin
    lost = bits.rbit | bits.stk;
    unique case (rc)
      RC_NEAR: inc = bits.rbit & (bits.stk | bits.lsb);
      RC_DOWN: inc = sign & lost;
      RC_UP:   inc = ~sign & lost;
      default: inc = 1'b0;
    endcase
    inexact = lost;
  end

endmodule

// File: rtl/rnd_add.sv
module rnd_add #(
  parameter int SIG_W = 64,
  parameter int EXP_W = 16
)(
  input  logic [SIG_W-1:0] kept,
  input  logic [SIG_W-1:0] unit,
  input  logic             inc,
  input  logic [EXP_W-1:0] exp_in,
  output logic [SIG_W-1:0] sig_out,
  output logic [EXP_W-1:0] exp_out,
  output logic             carry
);

  localparam logic [SIG_W-1:0] LEAD = {1'b1, {(SIG_W-1){1'b0}}};

  logic [SIG_W:0] sum;

  always_comb begin
    sum   = {1'b0, kept} + (inc ? {1'b0, unit} : '0);
    carry = sum[SIG_W];
    if (carry) begin
      sig_out = LEAD;
      exp_out = exp_in + EXP_W'(1);
    end else begin
      sig_out = sum[SIG_W-1:0];
      exp_out = exp_in;
    end
  end

endmodule

// File: rtl/rnd_unit.sv
module rnd_unit
  import rnd_pkg::*;
#(
  parameter int SIG_W = 64,
  parameter int EXP_W = 16,
  parameter int P_LO  = 24,
  parameter int P_MID = 53
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_rc,
  input  logic [1:0]       cfg_pc,
  input  logic             in_valid,
  input  logic             in_sign,
  input  logic [EXP_W-1:0] in_exp,
  input  logic [SIG_W-1:0] in_sig,
  input  logic             in_guard,
  input  logic             in_round,
  input  logic             in_sticky,
  output logic             out_valid,
  output logic [SIG_W-1:0] out_sig,
  output logic [EXP_W-1:0] out_exp,
  output logic             out_inexact
);

  localparam int LO_DROP  = SIG_W - P_LO;
  localparam int MID_DROP = SIG_W - P_MID;

  rc_e rc_q;
  pc_e pc_q;

  rnd_mode_reg u_mode (
    .clk    (clk),
    .rst_n  (rst_n),
    .cfg_we (cfg_we),
    .cfg_rc (cfg_rc),
    .cfg_pc (cfg_pc),
    .rc_q   (rc_q),
    .pc_q   (pc_q)
  );

  logic [SIG_W-1:0] kept, unit;
  rnd_bits_t        bits;

  rnd_fold #(.SIG_W(SIG_W), .P_LO(P_LO), .P_MID(P_MID)) u_fold (
    .sig  (in_sig),
    .grs  ({in_guard, in_round, in_sticky}),
    .pc   (pc_q),
    .kept (kept),
    .unit (unit),
    .bits (bits)
  );

  logic inc, inexact;

  rnd_decide u_decide (
    .sign    (in_sign),
    .rc      (rc_q),
    .bits    (bits),
    .inc     (inc),
    .inexact (inexact)
  );

  logic [SIG_W-1:0] sig_rnd;
  logic [EXP_W-1:0] exp_rnd;
  logic             carry;

  rnd_add #(.SIG_W(SIG_W), .EXP_W(EXP_W)) u_add (
    .kept    (kept),
    .unit    (unit),
    .inc     (inc),
    .exp_in  (in_exp),
    .sig_out (sig_rnd),
    .exp_out (exp_rnd),
    .carry   (carry)
  );

  // output stage: next-state then register
  logic             valid_d;
  logic [SIG_W-1:0] sig_d;
  logic [EXP_W-1:0] exp_d;
  logic             inex_d;

  always_comb begin
    valid_d = in_valid;
    sig_d   = out_sig;
    exp_d   = out_exp;
    inex_d  = out_inexact;
    if (in_valid) begin
      sig_d  = sig_rnd;
      exp_d  = exp_rnd;
      inex_d = inexact;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_sig     <= '0;
      out_exp     <= '0;
      out_inexact <= 1'b0;
    end else begin
      out_valid   <= valid_d;
      out_sig     <= sig_d;
      out_exp     <= exp_d;
      out_inexact <= inex_d;
    end
  end

  // R2: result strobe tracks the sample strobe one cycle later
  a_r2_valid_follow: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r2_valid_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R7: truncation never grows the magnitude
  a_r7_trunc_no_inc: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && rc_q == RC_ZERO) |-> !inc);

  // R5 / R6: directed modes step only on their own sign
  a_r5_down_neg_only: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && rc_q == RC_DOWN && inc) |-> in_sign);
  a_r6_up_pos_only: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && rc_q == RC_UP && inc) |-> !in_sign);

  // R8: an increment is only possible on an inexact sample
  a_r8_inc_needs_loss: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && inc) |-> inexact);

  // R3: bits below the kept width are cleared after the adder
  a_r3_short_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && pc_q == PC_SHORT) |-> (sig_rnd[LO_DROP-1:0] == '0));
  a_r3_mid_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && pc_q == PC_MID) |-> (sig_rnd[MID_DROP-1:0] == '0));

  // R9: a carry always bumps the exponent
  a_r9_carry_exp: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && carry) |-> (exp_rnd != in_exp));

endmodule

// File: tb/rnd_unit_bench.sv
`timescale 1ns/1ps
module rnd_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_rc, cfg_pc;
  logic        in_valid, in_sign, in_guard, in_round, in_sticky;
  logic [15:0] in_exp;
  logic [63:0] in_sig;
  logic        out_valid, out_inexact;
  logic [63:0] out_sig;
  logic [15:0] out_exp;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

  always #2.5 clk = ~clk;

  rnd_unit u_rnd_unit (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_rc(cfg_rc), .cfg_pc(cfg_pc),
    .in_valid(in_valid), .in_sign(in_sign), .in_exp(in_exp), .in_sig(in_sig),
    .in_guard(in_guard), .in_round(in_round), .in_sticky(in_sticky),
    .out_valid(out_valid), .out_sig(out_sig), .out_exp(out_exp),
    .out_inexact(out_inexact)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] next_rng();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 7);
    rng = rng ^ (rng << 17);
    return rng;
  endfunction

  function automatic int kept_width(input logic [1:0] pc);
    return (pc == 2'b00) ? 24 : (pc == 2'b10) ? 53 : 64;
  endfunction

  // arithmetic reference: compare discarded remainder against one half
  task automatic ref_round(input logic sg, input logic [1:0] rc, input logic [1:0] pc,
                           input logic [63:0] sig, input logic [2:0] grs,
                           input logic [15:0] ex, output logic [63:0] es,
                           output logic [15:0] ee, output logic ei);
    int p = kept_width(pc);
    int sh = 64 - p;
    logic [66:0] ext = {sig, grs};
    logic [66:0] rem = ext & ((67'd1 << (sh + 3)) - 67'd1);
    logic [66:0] half = 67'd1 << (sh + 2);
    logic [64:0] k = {1'b0, sig >> sh};
    logic up;
    ei = (rem != 0);
    case (rc)
      2'b00: up = (rem > half) || (rem == half && k[0]);
      2'b01: up = sg && ei;
      2'b10: up = !sg && ei;
      default: up = 1'b0;
    endcase
    k = k + {64'd0, up};
    if (k == (65'd1 << p)) begin
      es = 64'h8000_0000_0000_0000;
      ee = ex + 16'd1;
    end else begin
      es = k[63:0] << sh;
      ee = ex;
    end
  endtask

  task automatic set_mode(input logic [1:0] rc, input logic [1:0] pc);
    @(negedge clk);
    cfg_we = 1'b1; cfg_rc = rc; cfg_pc = pc;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // drive one sample, then read its result one clock later
  task automatic apply(input logic sg, input logic [63:0] sig, input logic [2:0] grs,
                       input logic [15:0] ex);
    @(negedge clk);
    in_valid = 1'b1; in_sign = sg; in_sig = sig; in_exp = ex;
    {in_guard, in_round, in_sticky} = grs;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic check_sample(input string tag, input logic sg, input logic [1:0] rc,
                              input logic [1:0] pc, input logic [63:0] sig,
                              input logic [2:0] grs, input logic [15:0] ex);
    logic [63:0] es; logic [15:0] ee; logic ei;
    logic [63:0] lowmask;
    ref_round(sg, rc, pc, sig, grs, ex, es, ee, ei);
    lowmask = ~({64{1'b1}} << (64 - kept_width(pc)));
    apply(sg, sig, grs, ex);
    chk(tag, out_sig, es);
    chk("R9 exponent", {48'd0, out_exp}, {48'd0, ee});
    chk("R8 inexact", {63'd0, out_inexact}, {63'd0, ei});
    chk("R3 low bits", out_sig & lowmask, 64'd0);
  endtask

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_rc = 2'b00; cfg_pc = 2'b00;
    in_valid = 1'b0; in_sign = 1'b0; in_exp = '0; in_sig = '0;
    in_guard = 1'b0; in_round = 1'b0; in_sticky = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 valid in reset", {63'd0, out_valid}, 64'd0);
    chk("R1 sig in reset", out_sig, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 exp after reset", {48'd0, out_exp}, 64'd0);
    chk("R1 inexact after reset", {63'd0, out_inexact}, 64'd0);

    // R1 default mode: nearest-even at 64 bits; tie on odd LSB rounds up
    check_sample("R1 default tie odd", 1'b0, 2'b00, 2'b11, 64'h0000_0000_0000_0101, 3'b100, 16'h3FFF);
    check_sample("R1 default tie even", 1'b0, 2'b00, 2'b11, 64'h8000_0000_0000_0100, 3'b100, 16'h3FFF);
    // R2 strobe drops after an idle cycle
    @(negedge clk);
    chk("R2 valid low when idle", {63'd0, out_valid}, 64'd0);

    for (int rc = 0; rc < 4; rc++) begin
      for (int pc = 0; pc < 4; pc++) begin
        set_mode(rc[1:0], pc[1:0]);
        for (int s = 0; s < 2; s++) begin
          for (int i = 0; i < 40; i++) begin
            int d = 64 - kept_width(pc[1:0]);
            logic [63:0] km = {64{1'b1}} << d;
            logic [63:0] r = next_rng();
            logic [63:0] half_bit = (d > 0) ? (64'd1 << (d - 1)) : 64'd0;
            logic [2:0]  hg = (d > 0) ? 3'b000 : 3'b100;
            logic [63:0] sig;
            logic [2:0]  grs;
            string tag;
            case (i % 8)
              0: begin sig = {64{1'b1}}; grs = 3'b111; end
              1: begin sig = r; grs = next_rng() & 3'h7; end
              2: begin sig = (r & km & ~(64'd1 << d)) | half_bit; grs = hg; end
              3: begin sig = r & km; grs = 3'b000; end
              4: begin sig = (r & km) | (64'd1 << d) | half_bit; grs = hg; end
              5: begin sig = (r & km) | half_bit; grs = hg | 3'b001; end
              6: begin sig = 64'd0; grs = next_rng() & 3'h7; end
              default: begin sig = r >> 1; grs = next_rng() & 3'h7; end
            endcase
            case (rc)
              0: tag = "R4 nearest";
              1: tag = "R5 down";
              2: tag = "R6 up";
              default: tag = "R7 truncate";
            endcase
            check_sample(tag, s[0], rc[1:0], pc[1:0], sig, grs, 16'(i * 1031));
          end
        end
      end
    end

    // R9 exponent wrap on carry
    set_mode(2'b10, 2'b00);
    check_sample("R9 carry wrap", 1'b0, 2'b10, 2'b00, 64'hFFFF_FF00_0000_0001, 3'b000, 16'hFFFF);

    // R10 write coinciding with a sample uses the old mode (truncate)
    set_mode(2'b11, 2'b11);
    @(negedge clk);
    cfg_we = 1'b1; cfg_rc = 2'b10; cfg_pc = 2'b11;
    in_valid = 1'b1; in_sign = 1'b0; in_sig = 64'h0000_0000_0000_0010; in_exp = 16'h0100;
    {in_guard, in_round, in_sticky} = 3'b001;
    @(negedge clk);
    cfg_we = 1'b0; in_valid = 1'b0;
    chk("R10 old mode on write edge", out_sig, 64'h0000_0000_0000_0010);
    chk("R2 valid after sample", {63'd0, out_valid}, 64'd1);
    check_sample("R10 new mode after write", 1'b0, 2'b10, 2'b11, 64'h0000_0000_0000_0010, 3'b001, 16'h0100);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule